// File: doc/BRIEF.md
# Shared GPIO Port with Converter Pin Override

This block is the register and pin-control logic of a byte-wide general-purpose I/O port. Some of its pins can be lent to an analog-to-digital converter. Software writes a data latch and a direction register over a small register bus. The block turns these two registers into a per-pin output enable and output value, and it returns a read value for every pin.

The converter's control logic supplies two inputs: an active flag and a channel number. While the flag is high, the channel number names one of the shareable pins. That pin is forced to input, whatever its direction bit holds. Its read value then comes from the direction bit and the latch, not from the pad. Every other pin stays an ordinary bidirectional GPIO.

Register writes to a claimed pin still land in the stored registers. Only the pin's drive is held off, so the stored settings take effect as soon as the converter releases the pin.

Top module: `gpio_adc_share`

## Requirements
- R1: During and after reset, the data latch and the direction register are all zeros, so every output enable is low and every pin starts as an input.
- R2: A bus write with `regAddr` = 0 loads `regWrData` into the data latch at the clock edge. `padOut` always presents the data latch.
- R3: A bus write with `regAddr` = 1 loads the direction register. A read with `regAddr` = 1 returns the stored direction register. For an unclaimed pin, `padOe` equals its direction bit (1 = output).
- R4: With `regAddr` = 0, an unclaimed pin whose direction bit is 0 reads the pad input through a two-flop synchronizer. A pad change is visible after the second rising edge and not after the first.
- R5: With `regAddr` = 0, an unclaimed pin whose direction bit is 1 reads its data latch bit.
- R6: With `adcActive` high, channel numbers 0, 1, 2 and 3 claim pins 0, 1, 4 and 5 respectively. A claimed pin has `padOe` low even when its direction bit is 1. At most one pin is claimed at a time.
- R7: A claimed pin whose direction bit is 0 reads 0 on data reads, whatever its pad level.
- R8: A claimed pin whose direction bit is 1 reads its data latch bit on data reads.
- R9: No pin is claimed when `adcActive` is low or when `adcChSel` is 4 or above.
- R10: Data and direction writes made while a pin is claimed update the stored bits. The claimed pin's `padOe` stays low until release, and then it follows the newly stored direction bit.
- R11: While one pin is claimed, every other pin keeps its normal drive and read behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 = data latch, 1 = direction |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register |
| adcActive | input | 1 | Converter is enabled and claims a pin |
| adcChSel | input | 3 | Converter channel number |
| padIn | input | 8 | Pad input levels (asynchronous) |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables, 1 = drive |

## Verification
The bench walks the converter across all four shareable channels and compares the claimed pin's read value with both direction settings. A design that let the pad leak through would show a 1 where a 0 belongs, and one that ignored the latch would hide the stored value. It also writes the direction and data registers while a pin is claimed and then releases the pin. A design that blocked those writes would come back with stale settings, and one that let the direction write through at once would drive a pin the converter owns. Out-of-range channels, the inactive flag and the synchronizer's two-edge latency are each checked, which exposes a design that claims a wrong pin or samples the pad one cycle early.

// File: rtl/gpio_adc_share_pkg.sv
package gpio_adc_share_pkg;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;

  typedef struct packed {
    logic loadData;
    logic loadDir;
  } gpioStrobes_t;

endpackage

// File: rtl/gpio_adc_share_ctrl.sv
module gpio_adc_share_ctrl
  import gpio_adc_share_pkg::*;
#(
  parameter int                WIDTH       = 8,
  parameter int                CH_W        = 3,
  parameter logic [WIDTH-1:0]  SHARED_MASK = 8'b0011_0011
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic             adcActive,
  input  logic [CH_W-1:0]  adcChSel,
  output gpioStrobes_t     strobes,
  output logic [WIDTH-1:0] claimMask
);

  always_comb begin
    strobes.loadData = regWrEn && (regAddr == ADDR_DATA);
    strobes.loadDir  = regWrEn && (regAddr == ADDR_DIR);
  end

  // Channel k claims the k-th shareable pin counted from bit 0.
  always_comb begin
    int chanIdx;
    chanIdx   = 0;
    claimMask = '0;
    for (int p = 0; p < WIDTH; p++) begin
      if (SHARED_MASK[p]) begin
        if (adcActive && (int'(adcChSel) == chanIdx))
          claimMask[p] = 1'b1;
        chanIdx++;
      end
    end
  end

  a_r6_single_claim: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(claimMask));
  a_r6_shared_only: assert property (@(posedge clk) disable iff (!rstN)
    (claimMask & ~SHARED_MASK) == '0);
  a_r9_idle_no_claim: assert property (@(posedge clk) disable iff (!rstN)
    !adcActive |-> (claimMask == '0));

endmodule

// File: rtl/gpio_adc_share_dp.sv
module gpio_adc_share_dp
  import gpio_adc_share_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdSelDir,
  input  logic [WIDTH-1:0] claimMask,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] dataQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
    end else begin
      if (strobes.loadData) dataQ <= wrData;
      if (strobes.loadDir)  dirQ  <= wrData;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : gPin
      always_comb begin
        if (dirQ[b])           pinRead[b] = dataQ[b];
        else if (claimMask[b]) pinRead[b] = 1'b0;
        else                   pinRead[b] = syncQ[SYNC_STAGES-1][b];
      end
      assign padOe[b] = dirQ[b] & ~claimMask[b];
    end
  endgenerate

  assign padOut = dataQ;
  assign rdData = rdSelDir ? dirQ : pinRead;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (dataQ == '0 && dirQ == '0));
  a_r2_data_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadData |=> dataQ == $past(wrData));
  a_r3_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDir |=> dirQ == $past(wrData));
  a_r6_claim_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & claimMask) == '0);
  a_r7_claim_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdSelDir |-> ((rdData & claimMask & ~dirQ) == '0));

endmodule

// File: rtl/gpio_adc_share.sv
module gpio_adc_share
  import gpio_adc_share_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               CH_W        = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] SHARED_MASK = 8'b0011_0011
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic             adcActive,
  input  logic [CH_W-1:0]  adcChSel,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe
);

  gpioStrobes_t     strobes;
  logic [WIDTH-1:0] claimMask;

  gpio_adc_share_ctrl #(
    .WIDTH(WIDTH), .CH_W(CH_W), .SHARED_MASK(SHARED_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .adcActive(adcActive), .adcChSel(adcChSel),
    .strobes(strobes), .claimMask(claimMask)
  );

  gpio_adc_share_dp #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .rdSelDir(regAddr == ADDR_DIR), .claimMask(claimMask), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .rdData(regRdData)
  );

endmodule

// File: tb/tb_gpio_adc_share.sv
module tb_gpio_adc_share;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic       regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       adcActive;
  logic [2:0] adcChSel;
  logic [7:0] padIn;
  logic [7:0] padOut;
  logic [7:0] padOe;

  int testsRun = 0;
  int testsFailed = 0;
  bit allDone = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic [7:0] oe;
    logic [7:0] out;
  } expItem_t;

  expItem_t scoreQ[$];

  always #10 clk = ~clk;

  gpio_adc_share dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .adcActive(adcActive),
    .adcChSel(adcChSel), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // Monitor: compares queued expectations against the ports at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        testsRun++;
        if (regRdData !== it.rd || padOe !== it.oe || padOut !== it.out) begin
          testsFailed++;
          $display("FAIL %s: rd=%h oe=%h out=%h expected rd=%h oe=%h out=%h",
                   it.tag, regRdData, padOe, padOut, it.rd, it.oe, it.out);
        end
      end
    end
  end

  task automatic regWrite(input logic addr, input logic [7:0] data);
    regAddr   = addr;
    regWrData = data;
    regWrEn   = 1'b1;
    @(posedge clk);
    #1;
    regWrEn   = 1'b0;
  endtask

  task automatic expectAt(input string tag, input logic addr,
                          input logic [7:0] rd, input logic [7:0] oe,
                          input logic [7:0] out);
    expItem_t it;
    regAddr = addr;
    #1;
    it.tag = tag; it.rd = rd; it.oe = oe; it.out = out;
    scoreQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 100000);
    if (!allDone) begin
      testsFailed++;
      $display("FAIL watchdog: rd=%h expected completion", regRdData);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
    adcActive = 1'b0; adcChSel = '0; padIn = 8'h00;
    idle(3);
    expectAt("R1 in reset", 1'b0, 8'h00, 8'h00, 8'h00);
    rstN = 1'b1;
    idle(1);
    expectAt("R1 after reset dir", 1'b1, 8'h00, 8'h00, 8'h00);

    // R2 R3: basic loads
    regWrite(1'b0, 8'hA7);
    regWrite(1'b1, 8'h0F);
    expectAt("R3 dir readback", 1'b1, 8'h0F, 8'h0F, 8'hA7);
    padIn = 8'h3C;
    idle(2);
    expectAt("R2 R5 R4 mixed read", 1'b0, 8'h37, 8'h0F, 8'hA7);

    // R4: two-edge synchronizer latency
    padIn = 8'hC0;
    expectAt("R4 after one edge", 1'b0, 8'h37, 8'h0F, 8'hA7);
    expectAt("R4 after two edges", 1'b0, 8'hC7, 8'h0F, 8'hA7);

    // R6 R8: claim pin 1 (dir 1, latch 1)
    adcActive = 1'b1; adcChSel = 3'd1;
    expectAt("R6 R8 ch1 claims pin1", 1'b0, 8'hC7, 8'h0D, 8'hA7);

    // R7 R11: claim pin 4 with dir 0 and pad high
    padIn = 8'hFF;
    adcActive = 1'b0;
    idle(2);
    expectAt("R4 pad high", 1'b0, 8'hF7, 8'h0F, 8'hA7);
    adcActive = 1'b1; adcChSel = 3'd2;
    expectAt("R7 R11 ch2 claims pin4", 1'b0, 8'hE7, 8'h0F, 8'hA7);
    adcChSel = 3'd3;
    expectAt("R7 ch3 claims pin5", 1'b0, 8'hD7, 8'h0F, 8'hA7);
    adcChSel = 3'd0;
    expectAt("R6 R8 ch0 claims pin0", 1'b0, 8'hF7, 8'h0E, 8'hA7);

    // R9: no claim
    adcChSel = 3'd4;
    expectAt("R9 ch4 no claim", 1'b0, 8'hF7, 8'h0F, 8'hA7);
    adcChSel = 3'd7;
    expectAt("R9 ch7 no claim", 1'b0, 8'hF7, 8'h0F, 8'hA7);
    adcActive = 1'b0; adcChSel = 3'd1;
    expectAt("R9 inactive no claim", 1'b0, 8'hF7, 8'h0F, 8'hA7);

    // R10: writes while pin0 claimed
    adcActive = 1'b1; adcChSel = 3'd0;
    regWrite(1'b1, 8'h0E);
    expectAt("R10 R7 dir cleared while claimed", 1'b0, 8'hF6, 8'h0E, 8'hA7);
    regWrite(1'b0, 8'hA6);
    regWrite(1'b1, 8'h0F);
    expectAt("R10 R8 writes stored drive held", 1'b0, 8'hF6, 8'h0E, 8'hA6);
    expectAt("R10 dir stored while claimed", 1'b1, 8'h0F, 8'h0E, 8'hA6);
    adcActive = 1'b0;
    expectAt("R10 release drives new setting", 1'b0, 8'hF6, 8'h0F, 8'hA6);

    allDone = 1'b1;
    idle(1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule